// File: doc/BRIEF.md
# ECC Page Status Aggregator

This block sits behind a NAND error-correction engine and turns the one-byte status the engine reports for each data chunk into a verdict for the whole page. Status bytes arrive on a valid-qualified stream, one per chunk, and the final chunk of a page is flagged with a last marker. Each byte is sorted into one of four classes: clean, erased, corrected with a bit count, or uncorrectable.

While a page streams in, the block tracks four figures. It keeps the largest corrected-bit count seen on any chunk, the sum of corrected bits on the page and the number of failed chunks, and it sets a flag once any chunk fails. A one-cycle result strobe follows the last chunk, and a page-clear input starts the next page. Two lifetime counters, total corrected bits and total failed chunks, survive page clears and stop at their maximum instead of wrapping. The flash driver reads the page flag and the worst-chunk count to choose between reporting a read failure and reporting the bit-flip level.

Top module: `ecc_page_status`

## Requirements
- R1: After reset, every output is zero.
- R2: A status byte 0x00 marks a clean chunk and leaves the maximum, the flag and all counters unchanged.
- R3: A status byte 0xFF marks an erased chunk and counts as neither corrected nor failed; no page or total figure changes.
- R4: A status byte from 0x01 to 0x28 is a corrected-bit count. `page_max` becomes the larger of its old value and the count, and the count is added to `page_corr` and to `total_corr`.
- R5: A status byte 0xFE, or any byte from 0x29 to 0xFD, marks an uncorrectable chunk. It sets `page_fail`, adds one to `page_fail_cnt` and to `total_fail`, and does not change `page_max`.
- R6: `res_valid` is high for exactly the one cycle after the clock edge that accepts a valid byte with `stat_last` high, and low at all other times. `stat_last` without `stat_valid` has no effect.
- R7: `page_clr` zeroes `page_max`, `page_fail`, `page_fail_cnt` and `page_corr` on the next edge and leaves `total_corr` and `total_fail` unchanged. A valid byte that arrives in the same cycle as `page_clr` is counted as the first chunk of the new page.
- R8: `total_corr` and `page_corr` saturate at their all-ones value instead of wrapping.
- R9: `total_fail` and `page_fail_cnt` saturate at their all-ones value instead of wrapping.
- R10: While `stat_valid` is low, `stat_byte` is ignored and no figure changes.
- R11: The correction threshold is inclusive. 0x28 (40) counts as corrected and 0x29 (41) counts as uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_clr | input | 1 | Start a new page: clear the per-page figures |
| stat_valid | input | 1 | `stat_byte` carries a chunk status this cycle |
| stat_byte | input | 8 | Chunk status code |
| stat_last | input | 1 | This status byte belongs to the final chunk of the page |
| res_valid | output | 1 | One-cycle strobe: the page figures are complete |
| page_fail | output | 1 | At least one chunk of the page is uncorrectable |
| page_max | output | 8 | Largest corrected-bit count on the page |
| page_fail_cnt | output | PG_W | Uncorrectable chunks on the page |
| page_corr | output | PSUM_W | Corrected bits summed over the page |
| total_corr | output | CORR_W | Lifetime corrected bits, saturating |
| total_fail | output | FAIL_W | Lifetime uncorrectable chunks, saturating |

## Verification
The classifier is tested with the two special codes, the values on both sides of the 40/41 threshold, 0xFD just below the uncorrectable code, and mixed pages of corrected counts that differ in size and order. These tests separate the running maximum from the running sum and show that erased chunks are excluded from both. Idle cycles with an uncorrectable byte and a last marker on the bus confirm that data without a valid qualifier changes nothing. Long runs of corrected and failed chunks drive every counter to saturation, and one page clear issued alone and one issued together with a status byte confirm that the lifetime totals outlive the page.

// File: rtl/ecc_page_status.sv
module ecc_page_status #(
  parameter int          MAX_FIX     = 40,
  parameter logic [7:0]  CODE_ERASED = 8'hFF,
  parameter logic [7:0]  CODE_UNCORR = 8'hFE,
  parameter int          PG_W        = 8,
  parameter int          PSUM_W      = 16,
  parameter int          CORR_W      = 16,
  parameter int          FAIL_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_clr,
  input  logic              stat_valid,
  input  logic [7:0]        stat_byte,
  input  logic              stat_last,
  output logic              res_valid,
  output logic              page_fail,
  output logic [7:0]        page_max,
  output logic [PG_W-1:0]   page_fail_cnt,
  output logic [PSUM_W-1:0] page_corr,
  output logic [CORR_W-1:0] total_corr,
  output logic [FAIL_W-1:0] total_fail
);
  localparam logic [7:0] FIX_LIM = 8'(MAX_FIX);

  logic is_erased, is_uncorr, is_fix;
  assign is_erased = (stat_byte == CODE_ERASED);
  assign is_uncorr = !is_erased && ((stat_byte == CODE_UNCORR) || (stat_byte > FIX_LIM));
  assign is_fix    = !is_erased && !is_uncorr && (stat_byte != 8'h00);

  logic              base_fail;
  logic [7:0]        base_max;
  logic [PG_W-1:0]   base_pfc;
  logic [PSUM_W-1:0] base_psum;
  assign base_fail = page_clr ? 1'b0 : page_fail;
  assign base_max  = page_clr ? 8'h00 : page_max;
  assign base_pfc  = page_clr ? '0 : page_fail_cnt;
  assign base_psum = page_clr ? '0 : page_corr;

  logic [PG_W:0]   pfc_inc;
  logic [PSUM_W:0] psum_add;
  logic [CORR_W:0] tc_add;
  logic [FAIL_W:0] tf_inc;
  assign pfc_inc  = {1'b0, base_pfc} + 1'b1;
  assign psum_add = {1'b0, base_psum} + (PSUM_W+1)'(stat_byte);
  assign tc_add   = {1'b0, total_corr} + (CORR_W+1)'(stat_byte);
  assign tf_inc   = {1'b0, total_fail} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      page_fail     <= 1'b0;
      page_max      <= 8'h00;
      page_fail_cnt <= '0;
      page_corr     <= '0;
      total_corr    <= '0;
      total_fail    <= '0;
    end else begin
      res_valid     <= stat_valid && stat_last;
      page_fail     <= base_fail;
      page_max      <= base_max;
      page_fail_cnt <= base_pfc;
      page_corr     <= base_psum;
      if (stat_valid && is_uncorr) begin
        page_fail     <= 1'b1;
        page_fail_cnt <= pfc_inc[PG_W] ? '1 : pfc_inc[PG_W-1:0];
        total_fail    <= tf_inc[FAIL_W] ? '1 : tf_inc[FAIL_W-1:0];
      end
      if (stat_valid && is_fix) begin
        if (stat_byte > base_max) page_max <= stat_byte;
        page_corr  <= psum_add[PSUM_W] ? '1 : psum_add[PSUM_W-1:0];
        total_corr <= tc_add[CORR_W] ? '1 : tc_add[CORR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ecc_page_status_chk.sv
module ecc_page_status_chk #(
  parameter int PG_W   = 8,
  parameter int PSUM_W = 16,
  parameter int CORR_W = 16,
  parameter int FAIL_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page_clr,
  input logic              stat_valid,
  input logic [7:0]        stat_byte,
  input logic              stat_last,
  input logic              res_valid,
  input logic              page_fail,
  input logic [7:0]        page_max,
  input logic [PG_W-1:0]   page_fail_cnt,
  input logic [PSUM_W-1:0] page_corr,
  input logic [CORR_W-1:0] total_corr,
  input logic [FAIL_W-1:0] total_fail
);
  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(stat_valid && stat_last));

  assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_last) |=> res_valid);

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_valid && !page_clr) |=> ($stable(page_max) && $stable(page_corr) &&
      $stable(page_fail) && $stable(total_corr) && $stable(total_fail)));

  assert_erased_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_byte == 8'hFF && !page_clr) |=>
      ($stable(page_max) && $stable(page_fail) && $stable(total_corr) && $stable(total_fail)));

  assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (page_fail && !page_clr) |=> page_fail);

  assert_clear_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (page_clr && !stat_valid) |=> (page_max == 8'h00 && !page_fail && page_fail_cnt == '0 && page_corr == '0));

  assert_clear_keeps_totals_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (page_clr && !stat_valid) |=> ($stable(total_corr) && $stable(total_fail)));

  assert_no_wrap_corr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (total_corr >= $past(total_corr)));

  assert_no_wrap_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (total_fail >= $past(total_fail)));
endmodule

bind ecc_page_status ecc_page_status_chk #(
  .PG_W(PG_W), .PSUM_W(PSUM_W), .CORR_W(CORR_W), .FAIL_W(FAIL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .page_clr(page_clr), .stat_valid(stat_valid),
  .stat_byte(stat_byte), .stat_last(stat_last), .res_valid(res_valid),
  .page_fail(page_fail), .page_max(page_max), .page_fail_cnt(page_fail_cnt),
  .page_corr(page_corr), .total_corr(total_corr), .total_fail(total_fail)
);

// File: tb/tb_ecc_page_status.sv
module tb_ecc_page_status;
  localparam int PG_W = 8, PSUM_W = 16, CORR_W = 16, FAIL_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page_clr = 1'b0, stat_valid = 1'b0, stat_last = 1'b0;
  logic [7:0] stat_byte = 8'h00;
  logic res_valid, page_fail;
  logic [7:0] page_max;
  logic [PG_W-1:0] page_fail_cnt;
  logic [PSUM_W-1:0] page_corr;
  logic [CORR_W-1:0] total_corr;
  logic [FAIL_W-1:0] total_fail;

  ecc_page_status dut (
    .clk(clk), .rst_n(rst_n), .page_clr(page_clr), .stat_valid(stat_valid),
    .stat_byte(stat_byte), .stat_last(stat_last), .res_valid(res_valid),
    .page_fail(page_fail), .page_max(page_max), .page_fail_cnt(page_fail_cnt),
    .page_corr(page_corr), .total_corr(total_corr), .total_fail(total_fail)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0;

  // expected model
  bit e_fail;
  int e_max, e_pfc, e_psum, e_tc, e_tf;

  function automatic int sat(int v, int w);
    int lim = (1 << w) - 1;
    return (v > lim) ? lim : v;
  endfunction

  function automatic void model_byte(logic [7:0] b);
    if (b == 8'hFF || b == 8'h00) return;
    if (b == 8'hFE || b > 8'd40) begin
      e_fail = 1; e_pfc = sat(e_pfc + 1, PG_W); e_tf = sat(e_tf + 1, FAIL_W);
    end else begin
      if (b > e_max) e_max = b;
      e_psum = sat(e_psum + b, PSUM_W); e_tc = sat(e_tc + b, CORR_W);
    end
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "page_fail", page_fail, e_fail);
    chk(req, "page_max", page_max, e_max);
    chk(req, "page_fail_cnt", page_fail_cnt, e_pfc);
    chk(req, "page_corr", page_corr, e_psum);
    chk(req, "total_corr", total_corr, e_tc);
    chk(req, "total_fail", total_fail, e_tf);
  endtask

  task automatic send(logic [7:0] b, bit last, bit clr = 0);
    @(negedge clk);
    stat_valid = 1; stat_byte = b; stat_last = last; page_clr = clr;
    if (clr) begin e_fail = 0; e_max = 0; e_pfc = 0; e_psum = 0; end
    model_byte(b);
    @(negedge clk);
    stat_valid = 0; stat_last = 0; page_clr = 0;
  endtask

  task automatic clear_page();
    @(negedge clk); page_clr = 1;
    @(negedge clk); page_clr = 0;
    e_fail = 0; e_max = 0; e_pfc = 0; e_psum = 0;
  endtask

  task automatic t_reset();
    e_fail = 0; e_max = 0; e_pfc = 0; e_psum = 0; e_tc = 0; e_tf = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "res_valid", res_valid, 0);
    chk_all("R1");
  endtask

  task automatic t_clean();
    clear_page();
    send(8'h00, 0); send(8'h00, 0);
    chk("R6", "res_valid mid-page", res_valid, 0);
    send(8'h00, 1);
    chk("R6", "res_valid after last", res_valid, 1);
    chk_all("R2");
    @(negedge clk);
    chk("R6", "res_valid one cycle only", res_valid, 0);
  endtask

  task automatic t_erased();
    clear_page();
    send(8'hFF, 0); send(8'd3, 0); send(8'hFF, 1);
    chk("R3", "res_valid", res_valid, 1);
    chk_all("R3");
  endtask

  task automatic t_corrected();
    clear_page();
    send(8'd5, 0); send(8'd12, 0); send(8'd7, 1);
    chk("R4", "page_max expect 12", page_max, 12);
    chk("R4", "page_corr expect 24", page_corr, 24);
    chk_all("R4");
  endtask

  task automatic t_boundary();
    clear_page();
    send(8'd40, 0);
    chk("R11", "40 not failing", page_fail, 0);
    chk("R11", "40 is max", page_max, 40);
    send(8'd41, 0);
    chk("R11", "41 fails", page_fail, 1);
    chk("R11", "41 fail count", page_fail_cnt, 1);
    send(8'hFE, 0); send(8'hFD, 1);
    chk("R5", "fail count after FE,FD", page_fail_cnt, 3);
    chk("R5", "max unchanged by failures", page_max, 40);
    chk_all("R5");
  endtask

  task automatic t_idle();
    @(negedge clk);
    stat_valid = 0; stat_byte = 8'hFE; stat_last = 1;
    repeat (4) begin
      @(negedge clk);
      chk("R6", "res_valid with last but no valid", res_valid, 0);
    end
    stat_byte = 8'd30;
    @(negedge clk);
    stat_last = 0;
    chk_all("R10");
  endtask

  task automatic t_clear();
    clear_page();
    chk_all("R7");
    chk("R7", "page_fail after clear", page_fail, 0);
    send(8'd9, 0, 1'b1);
    chk("R7", "byte with clear starts page", page_max, 9);
    chk_all("R7");
  endtask

  task automatic t_sat_corr();
    clear_page();
    for (int i = 0; i < 1700; i++) send(8'd40, 0);
    chk("R8", "total_corr saturated", total_corr, (1 << CORR_W) - 1);
    chk("R8", "page_corr saturated", page_corr, (1 << PSUM_W) - 1);
    chk_all("R8");
  endtask

  task automatic t_sat_fail();
    clear_page();
    for (int i = 0; i < 4100; i++) send(8'hFE, 0);
    chk("R9", "total_fail saturated", total_fail, (1 << FAIL_W) - 1);
    chk("R9", "page_fail_cnt saturated", page_fail_cnt, (1 << PG_W) - 1);
    chk_all("R9");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !finished) begin
      finished = 1;
      n_run++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean();
    t_erased();
    t_corrected();
    t_boundary();
    t_idle();
    t_clear();
    t_sat_corr();
    t_sat_fail();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule